// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. A shift register holds the outcomes of the most recent `M_BITS` resolved branches. That global pattern selects one of `2^M_BITS` counter banks. The low `K_BITS` of the branch address then pick one `N_BITS` saturating counter inside that bank. Total counter storage is `2^M_BITS * 2^K_BITS * N_BITS` bits. The default configuration holds 128 bits.

Fetch logic presents a branch address on the lookup port and gets a taken / not-taken answer in the same cycle, with no register in the path. When the branch resolves, the pipeline drives the update port with the branch address and its real outcome. The counter that the pre-update history and that address select moves one step toward the outcome. The outcome is then shifted into the history.

No tag is stored, so branches whose low address bits match share a counter. With `M_BITS = 0` the history is absent and the block reduces to a plain address-indexed table of counters.

Top module: `bp_corr_pred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value `2^(N_BITS-1)-1`, so every lookup predicts not-taken. The history is all zeros.
- R2: `lkp_taken_o` is the most significant bit of the selected counter. It follows `lkp_pc_i` combinationally, in the same cycle.
- R3: The lookup index is `{history, lkp_pc_i[K_BITS-1:0]}`, with the newest outcome in history bit 0. Address bits at and above `K_BITS` have no effect, so addresses that differ only in those bits alias onto one counter.
- R4: An update with `upd_taken_i = 1` increments the selected counter, which saturates at `2^N_BITS-1`.
- R5: An update with `upd_taken_i = 0` decrements the selected counter, which saturates at 0.
- R6: An update trains the counter indexed by the history held before that update and by `upd_pc_i[K_BITS-1:0]`. All other counters are unchanged.
- R7: Each update shifts `upd_taken_i` into history bit 0 and drops the oldest bit. Without `upd_valid_i` the history holds.
- R8: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update.
- R9: With 2-bit counters, a strongly-taken counter that receives one not-taken update still predicts taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | Address of the branch being predicted |
| lkp_taken_o | output | 1 | Prediction: 1 = taken |
| upd_valid_i | input | 1 | Applies one resolved branch |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome: 1 = taken |

## Verification
A counter in the wrong state shows up only as a wrong prediction. It becomes visible the first time a lookup combines that counter's history pattern with that address, which may happen many updates later. A history register in the wrong state is more visible: it redirects every lookup to another bank at once. The bench therefore sweeps all table addresses after every update of a long pseudo-random run and compares each answer against an arithmetic model. Any corrupted counter or history bit is caught within one update of the history reaching the affected bank.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned DEF_M_BITS = 2;
  localparam int unsigned DEF_N_BITS = 2;
  localparam int unsigned DEF_K_BITS = 4;
  localparam int unsigned DEF_PC_W   = 32;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned M_BITS = bp_pkg::DEF_M_BITS,
  localparam int unsigned HW    = (M_BITS > 0) ? M_BITS : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [HW-1:0] hist_o
);
  generate
    if (M_BITS == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, shift_i, bit_i};
      assign hist_o = '0;
    end else begin : g_reg
      logic [HW-1:0] hist_q;
      logic [HW:0]   ext;
      assign ext = {hist_q, bit_i};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= ext[HW-1:0];
      end
      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned N_BITS = bp_pkg::DEF_N_BITS,
  parameter int unsigned IDX_W  = bp_pkg::DEF_M_BITS + bp_pkg::DEF_K_BITS,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [N_BITS-1:0] rd_cnt_o,
  input  logic              wr_en_i,
  input  logic              wr_up_i,
  input  logic [IDX_W-1:0]  wr_idx_i
);
  localparam logic [N_BITS-1:0] CNT_MAX = '1;
  localparam logic [N_BITS-1:0] WEAK_NT = CNT_MAX >> 1;

  logic [ENTRIES-1:0][N_BITS-1:0] cnt_q;
  logic [N_BITS-1:0] wr_cur;

  assign wr_cur = cnt_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= WEAK_NT;
    end else if (wr_en_i) begin
      if (wr_up_i && wr_cur != CNT_MAX)  cnt_q[wr_idx_i] <= wr_cur + 1'b1;
      else if (!wr_up_i && wr_cur != '0) cnt_q[wr_idx_i] <= wr_cur - 1'b1;
    end
  end

  // read from the registered array: same-cycle update is not visible
  assign rd_cnt_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/bp_corr_pred.sv
module bp_corr_pred #(
  parameter int unsigned M_BITS = bp_pkg::DEF_M_BITS,
  parameter int unsigned N_BITS = bp_pkg::DEF_N_BITS,
  parameter int unsigned K_BITS = bp_pkg::DEF_K_BITS,
  parameter int unsigned PC_W   = bp_pkg::DEF_PC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            lkp_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned HW    = (M_BITS > 0) ? M_BITS : 1;
  localparam int unsigned IDX_W = M_BITS + K_BITS;

  logic [HW-1:0]     hist;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [N_BITS-1:0] rd_cnt;
  bp_pkg::dir_e      pred;

  bp_ghist #(.M_BITS(M_BITS)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  generate
    if (M_BITS == 0) begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist;
      assign rd_idx = lkp_pc_i[K_BITS-1:0];
      assign wr_idx = upd_pc_i[K_BITS-1:0];
    end else begin : g_corr
      assign rd_idx = {hist, lkp_pc_i[K_BITS-1:0]};
      assign wr_idx = {hist, upd_pc_i[K_BITS-1:0]};
    end
    if (PC_W > K_BITS) begin : g_hi
      logic unused_pc_hi;
      assign unused_pc_hi = ^{lkp_pc_i[PC_W-1:K_BITS], upd_pc_i[PC_W-1:K_BITS]};
    end
  endgenerate

  bp_ctr_table #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_cnt_o (rd_cnt),
    .wr_en_i  (upd_valid_i),
    .wr_up_i  (upd_taken_i),
    .wr_idx_i (wr_idx)
  );

  assign pred        = bp_pkg::dir_e'(rd_cnt[N_BITS-1]);
  assign lkp_taken_o = (pred == bp_pkg::DIR_TAKEN);
endmodule

// File: rtl/bp_corr_pred_chk.sv
module bp_table_chk #(
  parameter int unsigned N_BITS = 2,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic                           wr_up_i,
  input logic [IDX_W-1:0]               wr_idx_i,
  input logic [ENTRIES-1:0][N_BITS-1:0] cnt_q
);
  localparam logic [N_BITS-1:0] CMAX = '1;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cnt_q[wr_idx_i] != CMAX)
    |=> cnt_q[$past(wr_idx_i)] == $past(cnt_q[wr_idx_i]) + 1'b1); // R4
  AST_INC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cnt_q[wr_idx_i] == CMAX)
    |=> cnt_q[$past(wr_idx_i)] == CMAX); // R4
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cnt_q[wr_idx_i] != '0)
    |=> cnt_q[$past(wr_idx_i)] == $past(cnt_q[wr_idx_i]) - 1'b1); // R5
  AST_DEC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cnt_q[wr_idx_i] == '0)
    |=> cnt_q[$past(wr_idx_i)] == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cnt_q)); // R6
endmodule

module bp_hist_chk #(
  parameter int unsigned M_BITS = 2,
  localparam int unsigned HW = (M_BITS > 0) ? M_BITS : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          shift_i,
  input logic          bit_i,
  input logic [HW-1:0] hist_o
);
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o)); // R7
  generate
    if (M_BITS >= 1) begin : g_lsb
      AST_HIST_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> hist_o[0] == $past(bit_i)); // R7
    end
    if (M_BITS >= 2) begin : g_up
      AST_HIST_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> hist_o[HW-1:1] == $past(hist_o[HW-2:0])); // R7
    end
  endgenerate
endmodule

bind bp_ctr_table bp_table_chk #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_tbl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_up_i(wr_up_i),
  .wr_idx_i(wr_idx_i), .cnt_q(cnt_q)
);

bind bp_ghist bp_hist_chk #(.M_BITS(M_BITS)) u_hist_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift_i), .bit_i(bit_i), .hist_o(hist_o)
);

// File: tb/sim_bp_corr_pred.sv
module sim_bp_corr_pred;
  localparam int M = 2, N = 2, K = 4, PC_W = 32;
  localparam int TBL = 1 << K;
  localparam int NBANK = 1 << M;
  localparam int CMAX = (1 << N) - 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] lkp_pc_i = '0;
  logic            lkp_taken_o;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cnt_m [NBANK*TBL];
  int hist_m = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk_i = ~clk_i;

  bp_corr_pred #(.M_BITS(M), .N_BITS(N), .K_BITS(K), .PC_W(PC_W)) u0 (.*);

  function automatic bit model_pred(int pc);
    return cnt_m[hist_m*TBL + (pc % TBL)] >= (1 << (N-1));
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive address, let combinational path settle, compare (R2, R3)
  task automatic look(logic [PC_W-1:0] pc, string tag);
    lkp_pc_i = pc;
    #1;
    check(lkp_taken_o, model_pred(int'(pc[K-1:0])), tag);
  endtask

  // one update; the lookup in the same cycle targets the same counter (R8)
  task automatic update(logic [PC_W-1:0] pc, bit t);
    int idx;
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = t;
    look(pc ^ 32'hF000_0000, "R8 pre-update lookup");
    @(posedge clk_i);
    idx = hist_m*TBL + int'(pc[K-1:0]);
    if (t)  cnt_m[idx] = (cnt_m[idx] < CMAX) ? cnt_m[idx] + 1 : CMAX;
    else    cnt_m[idx] = (cnt_m[idx] > 0) ? cnt_m[idx] - 1 : 0;
    hist_m = ((hist_m << 1) | int'(t)) % NBANK;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int p = 0; p < TBL; p++) begin
      lfsr = next_rand(lfsr);
      look({lfsr[31:K], 4'(p)}, tag);
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBANK*TBL; i++) cnt_m[i] = (1 << (N-1)) - 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: all not-taken out of reset, upper address bits irrelevant (R3)
    sweep("R1 reset state");

    // R4 saturation and R9 hysteresis at address 5
    for (int i = 0; i < 6; i++) update(32'h0000_0005, 1'b1);
    sweep("R4 taken saturation");
    update(32'h0000_0005, 1'b0);
    update(32'h0000_0007, 1'b1);
    update(32'h0000_0007, 1'b1);
    look(32'h1234_5675, "R9 single not-taken keeps taken");

    // R5 saturation at 0
    for (int i = 0; i < 6; i++) update(32'h0000_0009, 1'b0);
    sweep("R5 not-taken saturation");

    // R7: alternating pattern selects banks 01/10
    for (int i = 0; i < 8; i++) update(32'h0000_0003, i[0]);
    sweep("R7 history pattern");

    // R6/R3: aliasing addresses train one counter
    for (int i = 0; i < 4; i++) update({24'(i+1), 8'h0C}, 1'b1);
    sweep("R3 alias training");

    // pseudo-random stream, full sweep after each update
    for (int i = 0; i < 2500; i++) begin
      lfsr = next_rand(lfsr);
      update(lfsr, lfsr[7] ^ lfsr[3]);
      sweep("R6 R4 R5 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule